// File: doc/BRIEF.md
# Interval Countdown Timer

This block is a memory-mapped down-counter with a 32-bit count and a 16-bit register port. Software programs the 32-bit reload period as two 16-bit halves. Control bits start and stop counting and pick one-shot or auto-reload operation. When the count reaches zero, a sticky timeout flag is set. Software clears the flag by writing 0 to it. While the interrupt enable is on, the flag drives the interrupt line. At 50 MHz, for example, a period of 5,000,000 cycles gives an interrupt every 100 ms.

A write to the low snapshot address freezes the live count into a holding register. Software then reads both halves of that register, so the two 16-bit reads always form one coherent 32-bit value. Writing either period half loads the whole new period into the counter and halts the timer.

The bus is synchronous. A write takes effect at the rising edge that ends the cycle in which `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register state.

The counting engine is a three-state machine:
- `ST_IDLE`: the timer is stopped.
- `ST_COUNT`: the count decrements once per cycle.
- `ST_WRAP`: the one cycle after zero, in continuous mode, in which the period is reloaded.

Its transitions are:
- IDLE→COUNT on a start request without a stop request.
- COUNT→IDLE on a stop request, or on reaching zero in one-shot mode.
- COUNT→WRAP on reaching zero in continuous mode.
- WRAP→COUNT when the period is reloaded.
- WRAP→IDLE on a stop request.
- Any state→IDLE on a period write.

Top module: `ivt_timer`

## Requirements
- R1: After a synchronous active-low reset, the timer is stopped. The timeout flag, interrupt enable, continuous bit, period, count and snapshot are all zero, `irq_o` is 0, and every address reads 0.
- R2: The word addresses are fixed. Address 0 is status: bit 0 is timeout, bit 1 is running. Address 1 is control: bit 0 is interrupt enable, bit 1 is continuous, bit 2 is start, bit 3 is stop. Address 2 is the period low half and address 3 the period high half. Address 4 is the snapshot low half and address 5 the snapshot high half. Addresses 6 and 7 read 0, unused upper bits read 0, and the start and stop bits read back as 0.
- R3: Writing control with bit 2 set while stopped starts the timer. From the following cycle, the count drops by one every cycle. A start write while the timer runs has no effect.
- R4: Writing control with bit 3 set stops the timer and holds the count. When bits 2 and 3 are written together, stop wins.
- R5: The cycle in which a running count of 1 or 0 becomes 0 sets the timeout flag. With control bit 1 clear, the timer stops there with the count at 0.
- R6: With control bit 1 set, the timer keeps running after reaching zero. The count reloads the period in the next cycle and then counts down again.
- R7: Writing status with bit 0 = 0 clears the timeout flag, and writing bit 0 = 1 leaves it unchanged. A flag set by the counter in the same cycle wins over the clear. Status writes never change the running bit.
- R8: `irq_o` is 1 exactly while the interrupt enable and the timeout flag are both 1.
- R9: A write to either period half updates that half. It also loads the whole new period into the count and stops the timer.
- R10: Any write to address 4 latches the count as it was before that edge. Addresses 4 and 5 then return the low and high halves of the latched value until the next snapshot write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | 3 | Word address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and `irq_o` follow the register state in the same cycle. A write is visible one edge after the cycle in which it is presented. A start write gives its first decrement one edge after that. Reaching zero in continuous mode costs one extra `ST_WRAP` cycle before the reloaded period appears. The bench drives inputs on the falling edge and samples 1 ns later. A behavioural model advances on each rising edge, and its read data and interrupt value are compared against the design every cycle. Directed checks use values worked out by hand from these latencies, such as a snapshot taken right after a start write returning the undecremented period.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WRAP  = 2'd2
    } ivt_state_e;

    // word offsets that software decodes
    localparam int OFS_STATUS = 0;
    localparam int OFS_CTRL   = 1;
    localparam int OFS_PERIOD = 2;

    // status bits
    localparam int STS_TO  = 0;
    localparam int STS_RUN = 1;

    // control bits
    localparam int CTL_IEN  = 0;
    localparam int CTL_CONT = 1;
    localparam int CTL_GO   = 2;
    localparam int CTL_HALT = 3;

endpackage

// File: rtl/ivt_ctl_regs.sv
module ivt_ctl_regs
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              hit_zero,
    output logic              ien_q,
    output logic              cont_q,
    output logic              timeout_q,
    output logic [CNT_W-1:0]  per_q,
    output logic [CNT_W-1:0]  per_nx,
    output logic              per_load,
    output logic              go_req,
    output logic              halt_req
);
    localparam int NHALF = CNT_W / BUS_W;

    logic             ctl_wr;
    logic             sts_wr;
    logic [NHALF-1:0] half_sel;

    assign ctl_wr = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    assign sts_wr = wr_en && (wr_addr == ADDR_W'(OFS_STATUS));

    genvar g;
    generate
        for (g = 0; g < NHALF; g++) begin : g_half
            assign half_sel[g] = wr_en && (wr_addr == ADDR_W'(OFS_PERIOD + g));
            assign per_nx[g*BUS_W +: BUS_W] =
                half_sel[g] ? wr_data : per_q[g*BUS_W +: BUS_W];
        end
    endgenerate

    assign per_load = |half_sel;
    assign go_req   = ctl_wr && wr_data[CTL_GO];
    assign halt_req = ctl_wr && wr_data[CTL_HALT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q     <= 1'b0;
            cont_q    <= 1'b0;
            timeout_q <= 1'b0;
            per_q     <= '0;
        end else begin
            per_q <= per_nx;
            if (ctl_wr) begin
                ien_q  <= wr_data[CTL_IEN];
                cont_q <= wr_data[CTL_CONT];
            end
            if (hit_zero) begin
                timeout_q <= 1'b1;
            end else if (sts_wr && !wr_data[STS_TO]) begin
                timeout_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ivt_count_fsm.sv
module ivt_count_fsm
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_req,
    input  logic             halt_req,
    input  logic             per_load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] per_q,
    input  logic             cont_q,
    output ivt_state_e       state_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             running,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ivt_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             at_end;

    assign at_end = (cnt_q <= ONE);

    // state register and count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (per_load) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (go_req && !halt_req) state_d = ST_COUNT;
                ST_COUNT: begin
                    if (halt_req)    state_d = ST_IDLE;
                    else if (at_end) state_d = cont_q ? ST_WRAP : ST_IDLE;
                end
                ST_WRAP:  state_d = halt_req ? ST_IDLE : ST_COUNT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs: count update and zero event
    always_comb begin
        cnt_d    = cnt_q;
        hit_zero = 1'b0;
        if (per_load) begin
            cnt_d = load_val;
        end else begin
            unique case (state_q)
                ST_IDLE:  cnt_d = cnt_q;
                ST_COUNT: begin
                    if (!halt_req) begin
                        if (at_end) begin
                            cnt_d    = '0;
                            hit_zero = 1'b1;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                ST_WRAP:  if (!halt_req) cnt_d = per_q;
                default:  cnt_d = cnt_q;
            endcase
        end
    end

    assign running = (state_q != ST_IDLE);

endmodule

// File: rtl/ivt_snap.sv
module ivt_snap #(
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 3,
    parameter int SNAP_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  snap_q
);
    logic cap;

    assign cap = wr_en && (wr_addr == ADDR_W'(SNAP_BASE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (cap) begin
            snap_q <= cnt_q;
        end
    end

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_o
);
    localparam int NHALF     = CNT_W / BUS_W;
    localparam int SNAP_BASE = OFS_PERIOD + NHALF;

    logic             ien_q;
    logic             cont_q;
    logic             timeout_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] per_nx;
    logic             per_load;
    logic             go_req;
    logic             halt_req;
    ivt_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             running;
    logic             hit_zero;
    logic [CNT_W-1:0] snap_q;

    ivt_ctl_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .hit_zero  (hit_zero),
        .ien_q     (ien_q),
        .cont_q    (cont_q),
        .timeout_q (timeout_q),
        .per_q     (per_q),
        .per_nx    (per_nx),
        .per_load  (per_load),
        .go_req    (go_req),
        .halt_req  (halt_req)
    );

    ivt_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_req   (go_req),
        .halt_req (halt_req),
        .per_load (per_load),
        .load_val (per_nx),
        .per_q    (per_q),
        .cont_q   (cont_q),
        .state_q  (state_q),
        .cnt_q    (cnt_q),
        .running  (running),
        .hit_zero (hit_zero)
    );

    ivt_snap #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SNAP_BASE(SNAP_BASE)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .cnt_q   (cnt_q),
        .snap_q  (snap_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_STATUS)) begin
            bus_rdata[STS_TO]  = timeout_q;
            bus_rdata[STS_RUN] = running;
        end else if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[CTL_IEN]  = ien_q;
            bus_rdata[CTL_CONT] = cont_q;
        end
        for (int i = 0; i < NHALF; i++) begin
            if (bus_addr == ADDR_W'(OFS_PERIOD + i)) bus_rdata = per_q[i*BUS_W +: BUS_W];
            if (bus_addr == ADDR_W'(SNAP_BASE + i))  bus_rdata = snap_q[i*BUS_W +: BUS_W];
        end
    end

    assign irq_o = ien_q & timeout_q;

endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  wdata,
    input logic              irq,
    input logic              running,
    input logic              timeout,
    input logic              ien,
    input logic              cont,
    input logic              hit,
    input ivt_state_e        state,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  per,
    input logic [CNT_W-1:0]  snap
);
    localparam int SNAP_BASE = OFS_PERIOD + CNT_W / BUS_W;

    logic ctl_w;
    logic sts_w;
    logic per_w;

    assign ctl_w = wr && (addr == ADDR_W'(OFS_CTRL));
    assign sts_w = wr && (addr == ADDR_W'(OFS_STATUS));
    assign per_w = wr && (addr == ADDR_W'(OFS_PERIOD) || addr == ADDR_W'(OFS_PERIOD + 1));

    // R3
    go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_w && wdata[CTL_GO] && !wdata[CTL_HALT] && !running |=> running);

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COUNT && cnt > CNT_W'(1) && !wr |=> cnt == $past(cnt) - CNT_W'(1));

    // R4
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_w && wdata[CTL_HALT] |=> !running);

    // R5
    oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !cont |=> !running && timeout && cnt == '0);

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WRAP && !wr |=> running && cnt == $past(per));

    // R7
    to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_w && !wdata[STS_TO] && !hit |=> !timeout);

    // R7
    run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_w && !hit |=> running == $past(running));

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $rose(timeout) || $rose(ien));

    // R9
    per_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_w |=> !running && cnt == per);

    // R10
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && addr == ADDR_W'(SNAP_BASE) |=> snap == $past(cnt));

endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .irq     (irq_o),
    .running (running),
    .timeout (timeout_q),
    .ien     (ien_q),
    .cont    (cont_q),
    .hit     (hit_zero),
    .state   (state_q),
    .cnt     (cnt_q),
    .per     (per_q),
    .snap    (snap_q)
);

// File: tb/ivt_timer_test.sv
`timescale 1ns/100ps
module ivt_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 1'b0;
    logic [2:0]  b_addr = 3'd0;
    logic [15:0] b_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int    n_run = 0;
    int    n_fail = 0;
    bit    live = 0;
    bit    done = 0;
    string cur_req = "R1";
    int    rot = 0;

    always #2.5 clk = ~clk;

    ivt_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (b_wr),
        .bus_addr  (b_addr),
        .bus_wdata (b_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // behavioural reference model
    longint unsigned m_cnt = 0, m_per = 0, m_snap = 0;
    int m_st = 0;          // 0 stopped, 1 counting, 2 reloading
    bit m_to = 0, m_ien = 0, m_cont = 0;

    always @(posedge clk) begin
        bit hit, ctl, sts, plo, phi, snw, go, halt;
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_snap = 0; m_st = 0;
            m_to = 0; m_ien = 0; m_cont = 0;
        end else begin
            hit  = 0;
            ctl  = b_wr && b_addr == 3'd1;
            sts  = b_wr && b_addr == 3'd0;
            plo  = b_wr && b_addr == 3'd2;
            phi  = b_wr && b_addr == 3'd3;
            snw  = b_wr && b_addr == 3'd4;
            go   = ctl && b_wdata[2];
            halt = ctl && b_wdata[3];
            if (snw) m_snap = m_cnt;
            if (plo || phi) begin
                if (plo) m_per = (m_per & 64'hFFFF_0000) | longint'(b_wdata);
                else     m_per = (m_per & 64'h0000_FFFF) | (longint'(b_wdata) << 16);
                m_cnt = m_per;
                m_st  = 0;
            end else begin
                case (m_st)
                    0: if (go && !halt) m_st = 1;
                    1: begin
                        if (halt) m_st = 0;
                        else if (m_cnt <= 1) begin
                            m_cnt = 0; hit = 1; m_st = m_cont ? 2 : 0;
                        end else m_cnt = m_cnt - 1;
                    end
                    default: begin
                        if (halt) m_st = 0;
                        else begin m_cnt = m_per; m_st = 1; end
                    end
                endcase
            end
            if (hit) m_to = 1;
            else if (sts && !b_wdata[0]) m_to = 0;
            if (ctl) begin m_ien = b_wdata[0]; m_cont = b_wdata[1]; end
        end
    end

    function automatic logic [15:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {14'h0, m_st != 0, m_to};
            3'd1: return {14'h0, m_cont, m_ien};
            3'd2: return m_per[15:0];
            3'd3: return m_per[31:16];
            3'd4: return m_snap[15:0];
            3'd5: return m_snap[31:16];
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && live) begin
            chk("R8 irq vs model", {15'h0, irq_o}, {15'h0, m_to && m_ien});
            chk(cur_req, bus_rdata, model_read(b_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        b_wr = 1'b1; b_addr = a; b_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            b_wr = 1'b0; b_addr = 3'(rot); rot = (rot + 1) % 6;
        end
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        b_wr = 1'b0; b_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1;

        cur_req = "R1 reset state";
        for (int a = 0; a < 6; a++) expect_reg(3'(a), 16'h0, "R1 reset reads zero");
        chk("R1 irq low", {15'h0, irq_o}, 16'h0);

        cur_req = "R5 one-shot";
        wr(3'd2, 16'd5);
        wr(3'd1, 16'h0005);
        idle(10);
        expect_reg(3'd0, 16'h0001, "R5 timeout set and stopped");
        chk("R8 irq high", {15'h0, irq_o}, 16'h1);
        wr(3'd4, 16'h0);
        expect_reg(3'd4, 16'h0000, "R5 count held at zero");

        cur_req = "R7 clear";
        wr(3'd0, 16'h0003);
        expect_reg(3'd0, 16'h0001, "R7 writing 1 keeps flag");
        wr(3'd0, 16'h0000);
        expect_reg(3'd0, 16'h0000, "R7 writing 0 clears flag");
        chk("R8 irq low after clear", {15'h0, irq_o}, 16'h0);

        cur_req = "R10 snapshot";
        wr(3'd2, 16'd100);
        wr(3'd1, 16'h0004);
        wr(3'd4, 16'h0);
        expect_reg(3'd4, 16'd100, "R10 snapshot right after start");
        wr(3'd4, 16'h0);
        expect_reg(3'd4, 16'd98, "R3 decrement per cycle");

        cur_req = "R4 stop";
        wr(3'd1, 16'h0008);
        expect_reg(3'd0, 16'h0000, "R4 stop halts");
        wr(3'd1, 16'h000C);
        expect_reg(3'd0, 16'h0000, "R4 stop wins over start");
        idle(4);

        cur_req = "R7 run bit";
        wr(3'd1, 16'h0004);
        wr(3'd0, 16'h0000);
        expect_reg(3'd0, 16'h0002, "R7 status write keeps running");

        cur_req = "R9 period write";
        wr(3'd2, 16'd7);
        expect_reg(3'd0, 16'h0000, "R9 period write stops");
        wr(3'd4, 16'h0);
        expect_reg(3'd4, 16'd7, "R9 period loaded into count");

        cur_req = "R6 continuous";
        wr(3'd2, 16'd3);
        wr(3'd1, 16'h0007);
        idle(30);
        expect_reg(3'd0, 16'h0003, "R6 still running after zero");
        chk("R8 irq in continuous", {15'h0, irq_o}, 16'h1);
        wr(3'd1, 16'h0008);
        wr(3'd0, 16'h0000);
        expect_reg(3'd0, 16'h0000, "R4 stopped and cleared");

        cur_req = "R2 map";
        wr(3'd3, 16'h0001);
        wr(3'd2, 16'h0000);
        expect_reg(3'd3, 16'h0001, "R2 period high");
        expect_reg(3'd2, 16'h0000, "R2 period low");
        wr(3'd1, 16'h0003);
        expect_reg(3'd1, 16'h0003, "R2 control readback");
        expect_reg(3'd6, 16'h0000, "R2 unused address 6");
        expect_reg(3'd7, 16'h0000, "R2 unused address 7");

        cur_req = "R10 borrow";
        wr(3'd1, 16'h0004);
        wr(3'd4, 16'h0);
        wr(3'd4, 16'h0);
        expect_reg(3'd4, 16'hFFFF, "R10 low half after borrow");
        expect_reg(3'd5, 16'h0000, "R10 high half after borrow");
        wr(3'd1, 16'h0008);

        cur_req = "R8 masked";
        wr(3'd3, 16'h0000);
        wr(3'd2, 16'd2);
        wr(3'd1, 16'h0006);
        idle(10);
        expect_reg(3'd0, 16'h0003, "R6 flag set, running");
        chk("R8 irq masked", {15'h0, irq_o}, 16'h0);
        wr(3'd1, 16'h0007);
        expect_reg(3'd1, 16'h0003, "R2 control after enable");
        chk("R8 irq after enable", {15'h0, irq_o}, 16'h1);

        cur_req = "R7 set wins";
        wr(3'd2, 16'd0);
        wr(3'd1, 16'h0006);
        for (int k = 0; k < 8; k++) wr(3'd0, 16'h0000);
        idle(4);
        wr(3'd1, 16'h0008);
        idle(3);

        cur_req = "R1 reset mid-run";
        wr(3'd2, 16'd9);
        wr(3'd1, 16'h0007);
        idle(3);
        @(negedge clk);
        rst_n = 1'b0; b_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 6; a++) expect_reg(3'(a), 16'h0, "R1 zero after reset");
        chk("R1 irq low after reset", {15'h0, irq_o}, 16'h0);

        idle(2);
        done = 1;
        summary();
        $finish;
    end

endmodule